// File: doc/BRIEF.md
# Indirect Peripheral Clock Control Register

This block holds the clock state of up to 64 peripherals behind one bus-visible word. Each peripheral has a clock enable and a 2-bit divide exponent. A bus write always selects a peripheral. When the write's command bit is set, the same write also loads a new enable and divider into that peripheral. The read port always shows the currently selected peripheral's stored state.

For every peripheral, the block drives the stored enable and divide exponent as outputs. From one free-running 3-bit counter on the parent clock it also derives a divided clock-enable pulse per peripheral. The pulse rate is the parent rate shifted right by the exponent, so a peripheral divides by 1, 2, 4 or 8.

Peripherals 0 and 1 are fixed. They are always enabled at divide-by-1, and commands that target them have no effect.

Top module: `pclk_reg_top`

## Requirements
- R1: After reset, peripherals 2 to 63 are disabled with exponent 0. Peripherals 0 and 1 are enabled with exponent 0. The selection is 0, so the read word is 0x1000_0000.
- R2: A write with the command bit (bit 12) clear only loads bits 5:0 into the selection. No peripheral's enable or exponent changes.
- R3: A write with bit 12 set and bit 28 set enables the peripheral whose number is in bits 5:0 and loads its exponent from bits 17:16. The write also selects that peripheral.
- R4: The read word carries the selection in bits 5:0, the selected peripheral's exponent in bits 17:16 and its enable in bit 28. All other bits read 0, including the command bit.
- R5: A write with bit 12 set and bit 28 clear disables the addressed peripheral. Its stored exponent keeps its previous value.
- R6: Peripherals 0 and 1 always read and drive enabled with exponent 0, whatever commands target them.
- R7: `periphEn[i]` equals peripheral i's stored enable. `periphDiv[2i+1:2i]` equals its stored exponent.
- R8: An enabled peripheral with exponent d raises `periphTick[i]` for exactly one cycle in every 2^d cycles, so it gives 64>>d pulses in any 64 consecutive cycles.
- R9: `periphTick[i]` stays low while peripheral i is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrite | input | 1 | Write strobe for the control word |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read word of the selected peripheral |
| periphEn | output | 64 | Per-peripheral clock enable |
| periphDiv | output | 128 | Per-peripheral divide exponent, 2 bits each |
| periphTick | output | 64 | Per-peripheral divided clock-enable pulse |

## Verification
A write takes effect at the clock edge that samples it. The selection, the stored state, the read word, the enable and exponent outputs and the pulse outputs are therefore all due one edge after the write. The bench drives each write on a falling edge and lowers the strobe on the next falling edge. It compares results at that falling edge, after the single rising edge in between. Pulse rates are measured by sampling the pulses on 64 consecutive falling edges, which is a whole number of counter periods, so the counter's phase cannot change the expected count.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  localparam int ID_W      = 6;
  localparam int DIV_W     = 2;
  localparam int DATA_W    = 32;
  localparam int CNT_W     = 3;
  localparam int FIXED_IDS = 2;
  localparam int ID_LSB    = 0;
  localparam int CMD_BIT   = 12;
  localparam int DIV_LSB   = 16;
  localparam int EN_BIT    = 28;

  typedef struct packed {
    logic             commit;
    logic [ID_W-1:0]  id;
    logic             en;
    logic [DIV_W-1:0] div;
  } pclk_strobe_t;
endpackage

// File: rtl/pclk_ctrl.sv
module pclk_ctrl
  import pclk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic [DATA_W-1:0] regWdata,
  output logic [ID_W-1:0]   selId,
  output pclk_strobe_t      strb
);
  logic [ID_W-1:0] wrId;
  logic            wrCmd;
  logic            unusedWdata;

  assign wrId  = regWdata[ID_LSB +: ID_W];
  assign wrCmd = regWdata[CMD_BIT];
  assign unusedWdata = ^{regWdata[31:29], regWdata[27:18], regWdata[15:13], regWdata[11:6]};

  always_comb begin
    strb.commit = regWrite && wrCmd && (wrId >= ID_W'(FIXED_IDS));
    strb.id     = wrId;
    strb.en     = regWdata[EN_BIT];
    strb.div    = regWdata[DIV_LSB +: DIV_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN)        selId <= '0;
    else if (regWrite) selId <= wrId;
  end

  // R2 / R3: every write moves the selection to the written identifier
  p_sel_latch_r2: assert property (@(posedge clk) disable iff (!rstN)
    regWrite |=> selId == $past(regWdata[ID_LSB +: ID_W]));
endmodule

// File: rtl/pclk_state.sv
module pclk_state
  import pclk_pkg::*;
#(
  parameter int NUM_ID = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pclk_strobe_t            strb,
  input  logic [ID_W-1:0]         selId,
  output logic [NUM_ID-1:0]       enVec,
  output logic [NUM_ID*DIV_W-1:0] divVec,
  output logic [DATA_W-1:0]       rdData
);
  logic [DIV_W-1:0] divArr [NUM_ID];

  for (genvar i = 0; i < NUM_ID; i++) begin : g_id
    if (i < FIXED_IDS) begin : g_fixed
      assign enVec[i]  = 1'b1;
      assign divArr[i] = '0;
    end else begin : g_ctl
      logic hit;
      assign hit = strb.commit && (strb.id == ID_W'(i));
      always_ff @(posedge clk) begin
        if (!rstN) begin
          enVec[i]  <= 1'b0;
          divArr[i] <= '0;
        end else if (hit) begin
          enVec[i] <= strb.en;
          if (strb.en) divArr[i] <= strb.div;
        end
      end
    end
    assign divVec[i*DIV_W +: DIV_W] = divArr[i];
  end

  always_comb begin
    rdData = '0;
    rdData[ID_LSB +: ID_W]   = selId;
    rdData[EN_BIT]           = enVec[selId];
    rdData[DIV_LSB +: DIV_W] = divArr[selId];
  end

  // R2: no commit strobe leaves every enable and exponent untouched
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> ($stable(enVec) && $stable(divVec)));
  // R3 / R5: a committed enable lands in the addressed peripheral
  p_commit_en_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> enVec[$past(strb.id)] == $past(strb.en));
  // R5: a disable keeps the stored exponent
  p_disable_keeps_div_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !strb.en) |=> $stable(divVec));
  // R6: fixed identifiers read enabled at divide-by-1
  p_fixed_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    (selId < ID_W'(FIXED_IDS)) |-> (rdData[EN_BIT] && rdData[DIV_LSB +: DIV_W] == '0));
endmodule

// File: rtl/pclk_tickgen.sv
module pclk_tickgen
  import pclk_pkg::*;
#(
  parameter int NUM_ID = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_ID-1:0]       enVec,
  input  logic [NUM_ID*DIV_W-1:0] divVec,
  output logic [NUM_ID-1:0]       tick
);
  logic [CNT_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rstN) phase <= '0;
    else       phase <= phase + 1'b1;
  end

  for (genvar i = 0; i < NUM_ID; i++) begin : g_tick
    logic [DIV_W-1:0] expo;
    logic [CNT_W-1:0] mask;
    assign expo = divVec[i*DIV_W +: DIV_W];
    assign mask = ~({CNT_W{1'b1}} << expo);
    assign tick[i] = enVec[i] && ((phase & mask) == mask);

    // R8: with a non-zero exponent a pulse is never followed by another
    p_pulse_width_r8: assert property (@(posedge clk) disable iff (!rstN)
      (tick[i] && expo != '0) |=> (!tick[i] || expo != $past(expo)));
  end

  // R8: the shared phase counter advances by one each cycle
  p_phase_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> phase == $past(phase) + 1'b1);
endmodule

// File: rtl/pclk_reg_top.sv
module pclk_reg_top
  import pclk_pkg::*;
#(
  parameter int NUM_ID = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWrite,
  input  logic [DATA_W-1:0]       regWdata,
  output logic [DATA_W-1:0]       regRdata,
  output logic [NUM_ID-1:0]       periphEn,
  output logic [NUM_ID*DIV_W-1:0] periphDiv,
  output logic [NUM_ID-1:0]       periphTick
);
  pclk_strobe_t    strb;
  logic [ID_W-1:0] selId;

  pclk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regWdata(regWdata),
    .selId(selId), .strb(strb)
  );

  pclk_state #(.NUM_ID(NUM_ID)) u_state (
    .clk(clk), .rstN(rstN), .strb(strb), .selId(selId),
    .enVec(periphEn), .divVec(periphDiv), .rdData(regRdata)
  );

  pclk_tickgen #(.NUM_ID(NUM_ID)) u_tick (
    .clk(clk), .rstN(rstN), .enVec(periphEn), .divVec(periphDiv),
    .tick(periphTick)
  );
endmodule

// File: tb/tb_pclk_reg_top.sv
module tb_pclk_reg_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWrite = 1'b0;
  logic [31:0]  regWdata = '0;
  logic [31:0]  regRdata;
  logic [63:0]  periphEn;
  logic [127:0] periphDiv;
  logic [63:0]  periphTick;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic       mEn  [64];
  logic [1:0] mDiv [64];
  logic [5:0] mSel;

  always #5 clk = ~clk;

  pclk_reg_top dut (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regWdata(regWdata),
    .regRdata(regRdata), .periphEn(periphEn), .periphDiv(periphDiv),
    .periphTick(periphTick)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkWord(input logic [5:0] id, input logic cmd,
                                         input logic en, input logic [1:0] dv);
    logic [31:0] w = '0;
    w[5:0] = id; w[12] = cmd; w[28] = en; w[17:16] = dv;
    return w;
  endfunction

  function automatic logic [31:0] expRead(input logic [5:0] id);
    return mkWord(id, 1'b0, mEn[id], mDiv[id]);
  endfunction

  function automatic logic [63:0] expEn();
    logic [63:0] v;
    for (int i = 0; i < 64; i++) v[i] = mEn[i];
    return v;
  endfunction

  function automatic logic [127:0] expDiv();
    logic [127:0] v;
    for (int i = 0; i < 64; i++) v[2*i +: 2] = mDiv[i];
    return v;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 64; i++) begin
      mEn[i] = (i < 2);
      mDiv[i] = 2'd0;
    end
    mSel = 6'd0;
  endtask

  task automatic doWrite(input logic [31:0] w);
    @(negedge clk);
    regWrite = 1'b1;
    regWdata = w;
    @(negedge clk);
    regWrite = 1'b0;
    mSel = w[5:0];
    if (w[12] && w[5:0] >= 6'd2) begin
      mEn[w[5:0]] = w[28];
      if (w[28]) mDiv[w[5:0]] = w[17:16];
    end
  endtask

  task automatic countTicks(output int cnt [64], output int dbl);
    logic [63:0] prev = '0;
    dbl = 0;
    for (int i = 0; i < 64; i++) cnt[i] = 0;
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      for (int i = 0; i < 64; i++) begin
        if (periphTick[i]) cnt[i]++;
        if (periphTick[i] && prev[i] && mDiv[i] != 2'd0) dbl++;
      end
      prev = periphTick;
    end
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cnt [64];
    int dbl;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 read", regRdata, 32'h1000_0000);
    check("R1 en", periphEn, 64'h3);
    check("R1 div", periphDiv, '0);

    // R3 / R6: commit enable with exponent id%4 to every identifier
    for (int id = 0; id < 64; id++) begin
      doWrite(mkWord(6'(id), 1'b1, 1'b1, 2'(id % 4)));
      check($sformatf("R3 R6 read id%0d", id), regRdata, expRead(6'(id)));
    end
    // R7 vector outputs
    check("R7 en", periphEn, expEn());
    check("R7 div", periphDiv, expDiv());

    // R8 tick rates
    countTicks(cnt, dbl);
    for (int i = 0; i < 64; i++)
      check($sformatf("R8 ticks id%0d", i), 128'(cnt[i]), 128'(64 >> mDiv[i]));
    check("R8 pulse width", 128'(dbl), 128'(0));

    // R5 disable odd identifiers from 3 up, exponent field written as 0
    for (int id = 3; id < 64; id += 2)
      doWrite(mkWord(6'(id), 1'b1, 1'b0, 2'd0));
    for (int id = 3; id < 16; id += 2) begin
      doWrite(mkWord(6'(id), 1'b0, 1'b0, 2'd0));
      check($sformatf("R5 read id%0d", id), regRdata,
            mkWord(6'(id), 1'b0, 1'b0, 2'(id % 4)));
    end
    check("R5 div kept", periphDiv, expDiv());
    check("R7 en after disable", periphEn, expEn());

    // R6 commands to fixed identifiers are ignored
    doWrite(mkWord(6'd0, 1'b1, 1'b0, 2'd3));
    check("R6 read id0", regRdata, mkWord(6'd0, 1'b0, 1'b1, 2'd0));
    doWrite(mkWord(6'd1, 1'b1, 1'b0, 2'd2));
    check("R6 read id1", regRdata, mkWord(6'd1, 1'b0, 1'b1, 2'd0));
    check("R6 en", periphEn[1:0], 2'b11);

    // R2 select-only write carrying enable and exponent bits
    doWrite(mkWord(6'd5, 1'b0, 1'b1, 2'd3));
    check("R2 read id5", regRdata, mkWord(6'd5, 1'b0, 1'b0, 2'd1));
    check("R2 en", periphEn, expEn());
    check("R2 div", periphDiv, expDiv());

    // R9 disabled identifiers stay silent, R8 for the rest
    countTicks(cnt, dbl);
    for (int i = 0; i < 64; i++)
      check($sformatf("R9 R8 ticks id%0d", i), 128'(cnt[i]),
            128'(mEn[i] ? (64 >> mDiv[i]) : 0));

    // R4 stray bits never reach the read word
    doWrite(32'hEFFC_EFCA);
    check("R4 read stray select", regRdata, expRead(6'h0A));
    doWrite(32'hFFFF_FFCC);
    check("R4 read stray commit", regRdata, mkWord(6'h0C, 1'b0, 1'b1, 2'd3));
    check("R4 cmd bit zero", 128'(regRdata[12]), 128'(0));

    // R1 second reset restores defaults
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    modelReset();
    check("R1 read after reset", regRdata, 32'h1000_0000);
    check("R1 en after reset", periphEn, 64'h3);
    check("R1 div after reset", periphDiv, '0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule